// File: doc/BRIEF.md
# Byte-Lane Write Merge Multiplexer

This block assembles the word that goes to the memory write port. It chooses each byte of that word from one of two sources. The first source, path A, is system write data taken from a write buffer. The second, path B, is corrected read data that is being written back to memory. Each of the byte lanes has its own select bit, so a partial system write can be merged into a corrected word to form a read-modify-write.

A mode input sets where the lane select bits come from. In direct mode an externally driven byte-enable bus steers the lanes. In buffered mode the enables that travelled with the data through the write FIFO steer them. The merged word is captured in a register on the memory-side clock when the input valid strobe is high. A valid flag comes out alongside the registered word.

Top module: `wr_merge_mux`

## Requirements
- R1: Reset is synchronous and active low. After any rising clock edge with `rst_n` low, `merged_data` is all zeros and `merged_valid` is 0.
- R2: Lane i covers bits 8*i+7 down to 8*i, and lane 0 is the least significant byte. A lane select of 0 puts the matching byte of `sys_wdata` (path A) into that lane of the merged word.
- R3: A lane select of 1 puts the matching byte of `fix_wdata` (path B) into that lane.
- R4: When `en_src_sel` is 0, bit i of `ext_lane_en` is the select for lane i, and `fifo_lane_en` has no effect on the output.
- R5: When `en_src_sel` is 1, bit i of `fifo_lane_en` is the select for lane i, and `ext_lane_en` has no effect on the output.
- R6: With `en_src_sel` at 0 and `ext_lane_en` all ones, the whole of `fix_wdata` is written back unchanged.
- R7: On a clock edge with `in_valid` high, the merged word is loaded into `merged_data`, where it is visible after that edge. `merged_valid` equals the value `in_valid` had at the previous edge.
- R8: On a clock edge with `in_valid` low, `merged_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Loads the merged word at this edge |
| en_src_sel | input | 1 | Enable source: 0 = external bus, 1 = FIFO enables |
| ext_lane_en | input | 8 | External per-lane select (1 = path B) |
| fifo_lane_en | input | 8 | Per-lane select read from the write FIFO |
| sys_wdata | input | 64 | Path A: system write data |
| fix_wdata | input | 64 | Path B: corrected write-back data |
| merged_data | output | 64 | Registered merged word |
| merged_valid | output | 1 | Registered word holds a fresh merge |

## Verification
The assertions check on every cycle that each registered lane follows the source its select named, that the chosen enable bus really is the one steering the lanes, that the valid flag trails the strobe by one edge, and that the word holds while no load happens. Only the bench scenarios show that specific mixed patterns come out with the right bytes, including a full-word write-back, alternating lanes and edge lanes only. The bench also confirms that the enable bus not selected leaves the output alone, and that a reset in the middle of a run clears a loaded word.

// File: rtl/wmm_pkg.sv
// Package: shared types for the byte-lane write merge multiplexer.
// Assumes byte-sized lanes; lane width lives here so that all modules agree.
package wmm_pkg;
    localparam int LANE_W = 8;

    // Where the per-lane select bits come from.
    typedef enum logic {
        SRC_EXT  = 1'b0,
        SRC_FIFO = 1'b1
    } en_src_e;
endpackage

// File: rtl/wmm_en_select.sv
// Module: picks the lane-select vector from the external enable bus or from
// the enables read out of the write FIFO. Purely combinational. Assumes both
// enable buses are stable for the cycle in which they are used.
module wmm_en_select
    import wmm_pkg::*;
#(
    parameter int LANES = 8
) (
    input  en_src_e            src_sel,
    input  logic [LANES-1:0]   ext_en,
    input  logic [LANES-1:0]   fifo_en,
    output logic [LANES-1:0]   lane_sel
);
    // Choose the enable source for all lanes at once.
    always_comb begin
        case (src_sel)
            SRC_FIFO: lane_sel = fifo_en;
            default:  lane_sel = ext_en;
        endcase
    end
endmodule

// File: rtl/wmm_lane_mux.sv
// Module: per-lane 2:1 multiplexer. Lane i (bits LW*i+LW-1 .. LW*i) takes
// path B when its select is 1 and path A otherwise. Combinational; assumes
// lane 0 is the least significant byte.
module wmm_lane_mux #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] path_a,
    input  logic [DATA_W-1:0] path_b,
    output logic [DATA_W-1:0] merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Steer one byte lane from its own select bit.
        always_comb begin
            merged[i*LANE_W +: LANE_W] = lane_sel[i] ? path_b[i*LANE_W +: LANE_W]
                                                     : path_a[i*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/wmm_out_reg.sv
// Module: output register for the merged word plus its valid flag.
// Loads only on a valid strobe, so it holds otherwise. Synchronous active-low
// reset clears both the word and the flag.
module wmm_out_reg #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              q_valid
);
    // Capture the merged word on a load and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // Valid flag trails the load strobe by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= load;
    end
endmodule

// File: rtl/wr_merge_mux.sv
// Module: byte-lane write merge multiplexer. Builds the memory write word
// lane by lane from system write data (path A) or corrected write-back data
// (path B). The lane selects come from an external enable bus or from FIFO
// buffered enables, as set by en_src_sel. Output is registered on clk.
// Assumes all inputs are synchronous to clk.
module wr_merge_mux
    import wmm_pkg::*;
#(
    parameter int LANES = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              en_src_sel,
    input  logic [LANES-1:0]  ext_lane_en,
    input  logic [LANES-1:0]  fifo_lane_en,
    input  logic [DATA_W-1:0] sys_wdata,
    input  logic [DATA_W-1:0] fix_wdata,
    output logic [DATA_W-1:0] merged_data,
    output logic              merged_valid
);
    logic [LANES-1:0]  lane_sel;
    logic [DATA_W-1:0] merged_comb;

    wmm_en_select #(.LANES(LANES)) u_sel (
        .src_sel  (en_src_e'(en_src_sel)),
        .ext_en   (ext_lane_en),
        .fifo_en  (fifo_lane_en),
        .lane_sel (lane_sel)
    );

    wmm_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_mux (
        .lane_sel (lane_sel),
        .path_a   (sys_wdata),
        .path_b   (fix_wdata),
        .merged   (merged_comb)
    );

    wmm_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (merged_comb),
        .q       (merged_data),
        .q_valid (merged_valid)
    );

    // R1: reset clears word and flag
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (merged_data == '0 && !merged_valid));

    // R7: valid flag follows the strobe by one edge
    p_valid_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> merged_valid);
    p_valid_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !merged_valid);

    // R8: no strobe, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(merged_data));

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        // R2: a lane with select 0 registers path A
        p_path_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !lane_sel[i]) |=>
            merged_data[i*LANE_W +: LANE_W] == $past(sys_wdata[i*LANE_W +: LANE_W]));
        // R3: a lane with select 1 registers path B
        p_path_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_sel[i]) |=>
            merged_data[i*LANE_W +: LANE_W] == $past(fix_wdata[i*LANE_W +: LANE_W]));
        // R4: direct mode follows the external enable bit
        p_ext_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !en_src_sel) |=>
            merged_data[i*LANE_W +: LANE_W] == ($past(ext_lane_en[i])
                ? $past(fix_wdata[i*LANE_W +: LANE_W])
                : $past(sys_wdata[i*LANE_W +: LANE_W])));
        // R5: buffered mode follows the FIFO enable bit
        p_fifo_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && en_src_sel) |=>
            merged_data[i*LANE_W +: LANE_W] == ($past(fifo_lane_en[i])
                ? $past(fix_wdata[i*LANE_W +: LANE_W])
                : $past(sys_wdata[i*LANE_W +: LANE_W])));
    end
endmodule

// File: tb/wr_merge_mux_test.sv
module wr_merge_mux_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        en_src_sel = 1'b0;
    logic [7:0]  ext_lane_en = '0;
    logic [7:0]  fifo_lane_en = '0;
    logic [63:0] sys_wdata = '0;
    logic [63:0] fix_wdata = '0;
    logic [63:0] merged_data;
    logic        merged_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    wr_merge_mux uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .en_src_sel(en_src_sel),
        .ext_lane_en(ext_lane_en), .fifo_lane_en(fifo_lane_en),
        .sys_wdata(sys_wdata), .fix_wdata(fix_wdata),
        .merged_data(merged_data), .merged_valid(merged_valid)
    );

    localparam logic [63:0] PAT_A = 64'hA7A6_A5A4_A3A2_A1A0;
    localparam logic [63:0] PAT_B = 64'hB7B6_B5B4_B3B2_B1B0;

    typedef struct packed {
        logic        sel;
        logic [7:0]  ext;
        logic [7:0]  fifo;
        logic [63:0] exp;
        logic [7:0]  req;   // requirement number, for the message only
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 8'hFF, 64'hA7A6_A5A4_A3A2_A1A0, 8'd2},
        '{1'b0, 8'hFF, 8'h00, 64'hB7B6_B5B4_B3B2_B1B0, 8'd6},
        '{1'b0, 8'h0F, 8'hF0, 64'hA7A6_A5A4_B3B2_B1B0, 8'd4},
        '{1'b1, 8'h0F, 8'hF0, 64'hB7B6_B5B4_A3A2_A1A0, 8'd5},
        '{1'b1, 8'hFF, 8'h55, 64'hA7B6_A5B4_A3B2_A1B0, 8'd5},
        '{1'b0, 8'h81, 8'h7E, 64'hB7A6_A5A4_A3A2_A1B0, 8'd3},
        '{1'b1, 8'h00, 8'hFF, 64'hB7B6_B5B4_B3B2_B1B0, 8'd3}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one merge at a negedge; sample one negedge later (after the posedge).
    task automatic merge_one(input logic sel, input logic [7:0] ext, input logic [7:0] fifo,
                             input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        en_src_sel = sel; ext_lane_en = ext; fifo_lane_en = fifo;
        sys_wdata = a; fix_wdata = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 data after reset", merged_data, 64'h0);
        check("R1 valid after reset", {63'h0, merged_valid}, 64'h0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 with R7 load timing
        for (int k = 0; k < NVEC; k++) begin
            merge_one(VECS[k].sel, VECS[k].ext, VECS[k].fifo, PAT_A, PAT_B);
            check($sformatf("R%0d vector %0d", VECS[k].req, k), merged_data, VECS[k].exp);
            check("R7 valid after load", {63'h0, merged_valid}, 64'h1);
        end

        // R7: valid falls one edge after the strobe drops
        @(negedge clk);
        check("R7 valid low without load", {63'h0, merged_valid}, 64'h0);

        // R8: inputs change without strobe, word holds
        en_src_sel = 1'b0; ext_lane_en = 8'h00; sys_wdata = 64'h1234_5678_9ABC_DEF0;
        repeat (2) @(negedge clk);
        check("R8 hold without strobe", merged_data, PAT_B);

        // R4: external mode ignores the FIFO enables (two FIFO patterns, same result)
        merge_one(1'b0, 8'h3C, 8'h00, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R4 fifo ignored pattern 1", merged_data, 64'h0000_FFFF_FFFF_0000);
        merge_one(1'b0, 8'h3C, 8'hFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R4 fifo ignored pattern 2", merged_data, 64'h0000_FFFF_FFFF_0000);

        // R5: FIFO mode ignores the external enables
        merge_one(1'b1, 8'hFF, 8'h01, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222);
        check("R5 ext ignored", merged_data, 64'h1111_1111_1111_1122);

        // R2: lane 7 is the top byte
        merge_one(1'b0, 8'h80, 8'h00, 64'h0, 64'hCD00_0000_0000_00EF);
        check("R2 lane 7 is most significant", merged_data, 64'hCD00_0000_0000_0000);

        // R1: reset mid-run clears a loaded word
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset data", merged_data, 64'h0);
        check("R1 mid-run reset valid", {63'h0, merged_valid}, 64'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule